// File: doc/BRIEF.md
# Register-to-Bus Operand Alignment Unit

This block adapts a 24-bit data bus to a register file whose registers have mixed widths. It handles 8-bit accumulator extensions, 24-bit data words, 16-bit address and control registers, small 8-bit and 6-bit control registers, and whole 56-bit accumulators. A 5-bit code names the target register class. A direction bit chooses between a register read and a register write.

On a read, the register file presents the selected register's raw contents, right-justified. The block puts that value on the bus. The unused upper bits are either sign-extended or forced to zero, depending on the register.

On a write, the block works out what the register file must store, and raises a single write enable. The source is either the bus word or an 8-bit short immediate. A short immediate is placed right-justified as an unsigned integer, or left-justified as a signed fraction, depending on the destination. A whole-accumulator destination gets a full 56-bit value: the word sits in the middle, the low word is cleared, and the extension is sign-filled.

The block is purely combinational. The clock and reset inputs only time its built-in checks.

Top module: `opalign_top`

Select codes:

| Codes | Register class |
|---|---|
| 0 to 3 | Data input words |
| 4, 5 | Accumulator low words |
| 6, 7 | Accumulator middle words |
| 8, 9 | Extensions |
| 10, 11 | Whole accumulators |
| 12 to 19 | 16-bit address and control registers |
| 20, 21 | 8-bit control registers |
| 22 | Mode register |
| 23 | Stack pointer |
| 24 to 31 | Unused |

## Requirements
- R1: Codes 0 to 7 (24-bit words) read `rd_raw[23:0]` unchanged onto the bus. On a bus write they store the whole bus word. Codes 10 and 11 (whole accumulator) read the middle word `rd_raw[47:24]`, with no limiting.
- R2: Reading an extension (codes 8, 9) puts `rd_raw[7:0]` on bus bits 7:0 and fills bits 23:8 with copies of `rd_raw[7]`.
- R3: A bus write to an extension stores only bus bits 7:0. Bus bits 23:8 have no effect.
- R4: Codes 12 to 19 (16-bit registers) read `rd_raw[15:0]` with bus bits 23:16 zero. On a write they store bus bits 15:0 only.
- R5: Codes 20 and 21 read `rd_raw[7:0]` zero-filled and store bus bits 7:0. Code 22 behaves the same, but bits outside `OMR_MASK` (default 8'hC7) read as zero and are stored as zero. Code 23 reads and stores 6 bits, zero-filled.
- R6: A bus write to a whole accumulator (codes 10, 11) yields a 56-bit value with the word in bits 47:24, zeros in bits 23:0, and bit 23 of the word copied into bits 55:48.
- R7: A bus write to a low word (codes 4, 5) stores the bus word alone, with all upper bits of `wr_val` zero.
- R8: A short immediate written to a low word, an extension, or a 16-bit register is stored right-justified and zero-extended.
- R9: A short immediate written to codes 0 to 3 or 6 to 7 is stored as `{imm, 16'h0}`. Written to a whole accumulator, that word is built as in R6.
- R10: Codes 24 to 31 read as zero and never raise `wr_en`.
- R11: While `dir_wr` is low, `wr_en` stays low and `imm_sel` has no effect. While `dir_wr` is high, `bus_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the built-in checks |
| rst_n | input | 1 | Active-low reset that disables the checks |
| reg_sel | input | 5 | Target register class code |
| dir_wr | input | 1 | 1 = write a register, 0 = read one onto the bus |
| imm_sel | input | 1 | Take the write source from `imm_data` instead of `bus_in` |
| imm_data | input | 8 | Short immediate |
| bus_in | input | 24 | Bus word for writes |
| rd_raw | input | 48 | Selected register contents, right-justified (a whole accumulator supplies its middle and low words) |
| bus_out | output | 24 | Aligned bus word for reads |
| wr_en | output | 1 | Write strobe to the register file |
| wr_val | output | 56 | Value to store, right-justified to the register width |

## Verification
The read path and the write path share every input. A single cycle can therefore present a live register value on `rd_raw` while the direction or the immediate flag selects the write side. The bench provokes this by driving junk-filled `rd_raw` during writes, and by setting `imm_sel` with a distinct immediate during reads. It judges the outcome by requiring a zero bus during writes, an untouched read result with `wr_en` low during reads, and write values that owe nothing to the unselected source.

// File: rtl/opalign_pkg.sv
package opalign_pkg;
  localparam int BUS_W = 24;
  localparam int EXT_W = 8;
  localparam int ADR_W = 16;
  localparam int CTL_W = 8;
  localparam int SP_W  = 6;
  localparam int IMM_W = 8;
  localparam int SEL_W = 5;
  localparam int RAW_W = 2 * BUS_W;
  localparam int ACC_W = EXT_W + 2 * BUS_W;

  typedef enum logic [3:0] {
    CL_WORD, CL_LOW, CL_EXT, CL_ACC, CL_W16, CL_C8, CL_OMR, CL_SP, CL_NONE
  } opclass_e;

  // Extension byte onto the bus, sign-filled.
  function automatic logic [BUS_W-1:0] sext_ext(input logic [EXT_W-1:0] v);
    return {{(BUS_W-EXT_W){v[EXT_W-1]}}, v};
  endfunction

  // Short immediate as a signed fraction: left-justified, low bits clear.
  function automatic logic [BUS_W-1:0] frac_word(input logic [IMM_W-1:0] v);
    return {v, {(BUS_W-IMM_W){1'b0}}};
  endfunction

  // Short immediate as an unsigned integer: right-justified.
  function automatic logic [BUS_W-1:0] int_word(input logic [IMM_W-1:0] v);
    return {{(BUS_W-IMM_W){1'b0}}, v};
  endfunction

  // Whole accumulator from one word: middle word, cleared low, sign-filled top.
  function automatic logic [ACC_W-1:0] acc_from_word(input logic [BUS_W-1:0] w);
    return {{EXT_W{w[BUS_W-1]}}, w, {BUS_W{1'b0}}};
  endfunction
endpackage

// File: rtl/opalign_decode.sv
module opalign_decode
  import opalign_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output opclass_e         cls
);
  always_comb begin
    unique case (sel)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd6, 5'd7:              cls = CL_WORD;
      5'd4, 5'd5:                                      cls = CL_LOW;
      5'd8, 5'd9:                                      cls = CL_EXT;
      5'd10, 5'd11:                                    cls = CL_ACC;
      5'd12, 5'd13, 5'd14, 5'd15,
      5'd16, 5'd17, 5'd18, 5'd19:                      cls = CL_W16;
      5'd20, 5'd21:                                    cls = CL_C8;
      5'd22:                                           cls = CL_OMR;
      5'd23:                                           cls = CL_SP;
      default:                                         cls = CL_NONE;
    endcase
  end
endmodule

// File: rtl/opalign_read.sv
module opalign_read
  import opalign_pkg::*;
#(
  parameter logic [CTL_W-1:0] OMR_MASK = 8'hC7
)(
  input  logic             clk,
  input  logic             rst_n,
  input  opclass_e         cls,
  input  logic             rd_en,
  input  logic [RAW_W-1:0] raw,
  output logic [BUS_W-1:0] bus_out
);
  logic [BUS_W-1:0] aligned;

  always_comb begin
    unique case (cls)
      CL_WORD, CL_LOW: aligned = raw[BUS_W-1:0];
      CL_ACC:          aligned = raw[RAW_W-1:BUS_W];
      CL_EXT:          aligned = sext_ext(raw[EXT_W-1:0]);
      CL_W16:          aligned = BUS_W'(raw[ADR_W-1:0]);
      CL_C8:           aligned = BUS_W'(raw[CTL_W-1:0]);
      CL_OMR:          aligned = BUS_W'(raw[CTL_W-1:0] & OMR_MASK);
      CL_SP:           aligned = BUS_W'(raw[SP_W-1:0]);
      default:         aligned = '0;
    endcase
  end

  assign bus_out = rd_en ? aligned : '0;

  // R2: the fill above bit 7 is uniform (all copies of one sign bit)
  assert_ext_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cls == CL_EXT) |->
      ($countones(bus_out[BUS_W-1:EXT_W-1]) == 0 ||
       $countones(bus_out[BUS_W-1:EXT_W-1]) == BUS_W-EXT_W+1));

  assert_w16_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cls == CL_W16) |-> bus_out[BUS_W-1:ADR_W] == '0);

  assert_omr_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cls == CL_OMR) |-> (bus_out[CTL_W-1:0] & ~OMR_MASK) == '0);
endmodule

// File: rtl/opalign_write.sv
module opalign_write
  import opalign_pkg::*;
#(
  parameter logic [CTL_W-1:0] OMR_MASK = 8'hC7
)(
  input  logic             clk,
  input  logic             rst_n,
  input  opclass_e         cls,
  input  logic             wr_req,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm,
  input  logic [BUS_W-1:0] bus_in,
  output logic             wr_en,
  output logic [ACC_W-1:0] wr_val
);
  logic [BUS_W-1:0] right_src;  // unsigned-integer view of the source
  logic [BUS_W-1:0] left_src;   // signed-fraction view of the source
  logic [ACC_W-1:0] shaped;

  assign right_src = imm_sel ? int_word(imm)  : bus_in;
  assign left_src  = imm_sel ? frac_word(imm) : bus_in;

  always_comb begin
    unique case (cls)
      CL_WORD: shaped = ACC_W'(left_src);
      CL_LOW:  shaped = ACC_W'(right_src);
      CL_EXT:  shaped = ACC_W'(right_src[EXT_W-1:0]);
      CL_ACC:  shaped = acc_from_word(left_src);
      CL_W16:  shaped = ACC_W'(right_src[ADR_W-1:0]);
      CL_C8:   shaped = ACC_W'(right_src[CTL_W-1:0]);
      CL_OMR:  shaped = ACC_W'(right_src[CTL_W-1:0] & OMR_MASK);
      CL_SP:   shaped = ACC_W'(right_src[SP_W-1:0]);
      default: shaped = '0;
    endcase
  end

  assign wr_en  = wr_req && (cls != CL_NONE);
  assign wr_val = wr_en ? shaped : '0;

  assert_acc_build_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cls == CL_ACC) |->
      (wr_val[BUS_W-1:0] == '0 &&
       ($countones(wr_val[ACC_W-1:2*BUS_W-1]) == 0 ||
        $countones(wr_val[ACC_W-1:2*BUS_W-1]) == EXT_W+1)));

  assert_imm_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && imm_sel && (cls == CL_LOW || cls == CL_EXT || cls == CL_W16)) |->
      wr_val[ACC_W-1:IMM_W] == '0);

  assert_imm_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && imm_sel && cls == CL_WORD) |->
      (wr_val[BUS_W-IMM_W-1:0] == '0 && wr_val[ACC_W-1:BUS_W] == '0));
endmodule

// File: rtl/opalign_top.sv
module opalign_top
  import opalign_pkg::*;
#(
  parameter logic [CTL_W-1:0] OMR_MASK = 8'hC7
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             dir_wr,
  input  logic             imm_sel,
  input  logic [IMM_W-1:0] imm_data,
  input  logic [BUS_W-1:0] bus_in,
  input  logic [RAW_W-1:0] rd_raw,
  output logic [BUS_W-1:0] bus_out,
  output logic             wr_en,
  output logic [ACC_W-1:0] wr_val
);
  opclass_e cls;

  opalign_decode u_dec (.sel(reg_sel), .cls(cls));

  opalign_read #(.OMR_MASK(OMR_MASK)) u_rd (
    .clk(clk), .rst_n(rst_n), .cls(cls), .rd_en(!dir_wr),
    .raw(rd_raw), .bus_out(bus_out)
  );

  opalign_write #(.OMR_MASK(OMR_MASK)) u_wr (
    .clk(clk), .rst_n(rst_n), .cls(cls), .wr_req(dir_wr),
    .imm_sel(imm_sel), .imm(imm_data), .bus_in(bus_in),
    .wr_en(wr_en), .wr_val(wr_val)
  );

  assert_unused_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel >= 5'd24) |-> (!wr_en && bus_out == '0));

  assert_read_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |-> !wr_en);

  assert_write_quiet_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |-> bus_out == '0);
endmodule

// File: tb/opalign_top_test.sv
module opalign_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_sel = '0;
  logic        dir_wr = 1'b0;
  logic        imm_sel = 1'b0;
  logic [7:0]  imm_data = '0;
  logic [23:0] bus_in = '0;
  logic [47:0] rd_raw = '0;
  logic [23:0] bus_out;
  logic        wr_en;
  logic [55:0] wr_val;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  opalign_top uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .dir_wr(dir_wr),
    .imm_sel(imm_sel), .imm_data(imm_data), .bus_in(bus_in), .rd_raw(rd_raw),
    .bus_out(bus_out), .wr_en(wr_en), .wr_val(wr_val)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [4:0]  sel;
    logic        wr;
    logic        imm;
    logic [7:0]  imm_d;
    logic [23:0] bus;
    logic [47:0] raw;
    logic [23:0] exp_bus;
    logic        exp_en;
    logic [55:0] exp_val;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    // R1 word read, whole-accumulator read of middle word, middle-word write
    '{8'd1, 5'd0,  1'b0, 1'b0, 8'h00, 24'h000000, 48'hFFFFFF_ABCDEF, 24'hABCDEF, 1'b0, 56'h0},
    '{8'd1, 5'd11, 1'b0, 1'b0, 8'h00, 24'h000000, 48'h345678_9ABCDE, 24'h345678, 1'b0, 56'h0},
    '{8'd1, 5'd6,  1'b1, 1'b0, 8'h00, 24'h111111, 48'hFFFFFF_FFFFFF, 24'h000000, 1'b1, 56'h111111},
    // R2 extension read, negative and positive
    '{8'd2, 5'd8,  1'b0, 1'b0, 8'h00, 24'h000000, 48'h000000_000085, 24'hFFFF85, 1'b0, 56'h0},
    '{8'd2, 5'd9,  1'b0, 1'b0, 8'h00, 24'h000000, 48'hFFFFFF_FFFF7F, 24'h00007F, 1'b0, 56'h0},
    // R3 extension write ignores bus bits 23:8
    '{8'd3, 5'd8,  1'b1, 1'b0, 8'h00, 24'h123456, 48'hFFFFFF_FFFFFF, 24'h000000, 1'b1, 56'h56},
    // R4 16-bit registers
    '{8'd4, 5'd12, 1'b0, 1'b0, 8'h00, 24'h000000, 48'hFFFFFF_FFBEEF, 24'h00BEEF, 1'b0, 56'h0},
    '{8'd4, 5'd14, 1'b1, 1'b0, 8'h00, 24'hABCDEF, 48'h000000_000000, 24'h000000, 1'b1, 56'hCDEF},
    '{8'd4, 5'd19, 1'b0, 1'b0, 8'h00, 24'h000000, 48'h000000_008001, 24'h008001, 1'b0, 56'h0},
    // R5 small control registers, mode-register mask, stack pointer
    '{8'd5, 5'd21, 1'b0, 1'b0, 8'h00, 24'h000000, 48'hFFFFFF_FFFFA5, 24'h0000A5, 1'b0, 56'h0},
    '{8'd5, 5'd20, 1'b1, 1'b0, 8'h00, 24'h00ABCD, 48'h000000_000000, 24'h000000, 1'b1, 56'hCD},
    '{8'd5, 5'd22, 1'b0, 1'b0, 8'h00, 24'h000000, 48'h000000_0000A5, 24'h000085, 1'b0, 56'h0},
    '{8'd5, 5'd22, 1'b1, 1'b0, 8'h00, 24'hFFFFFF, 48'h000000_000000, 24'h000000, 1'b1, 56'hC7},
    '{8'd5, 5'd23, 1'b0, 1'b0, 8'h00, 24'h000000, 48'h000000_0000FF, 24'h00003F, 1'b0, 56'h0},
    '{8'd5, 5'd23, 1'b1, 1'b0, 8'h00, 24'h0000FF, 48'h000000_000000, 24'h000000, 1'b1, 56'h3F},
    // R6 whole accumulator from bus word
    '{8'd6, 5'd10, 1'b1, 1'b0, 8'h00, 24'h800001, 48'h000000_000000, 24'h000000, 1'b1, 56'hFF_800001_000000},
    '{8'd6, 5'd11, 1'b1, 1'b0, 8'h00, 24'h123456, 48'h000000_000000, 24'h000000, 1'b1, 56'h00_123456_000000},
    // R7 low word alone
    '{8'd7, 5'd4,  1'b1, 1'b0, 8'h00, 24'h654321, 48'hFFFFFF_FFFFFF, 24'h000000, 1'b1, 56'h654321},
    // R8 right-justified immediates, bus junk ignored
    '{8'd8, 5'd4,  1'b1, 1'b1, 8'h9C, 24'hFFFFFF, 48'h000000_000000, 24'h000000, 1'b1, 56'h9C},
    '{8'd8, 5'd9,  1'b1, 1'b1, 8'hF0, 24'hFFFFFF, 48'h000000_000000, 24'h000000, 1'b1, 56'hF0},
    '{8'd8, 5'd13, 1'b1, 1'b1, 8'h3A, 24'hFFFFFF, 48'h000000_000000, 24'h000000, 1'b1, 56'h3A},
    // R9 left-justified immediates
    '{8'd9, 5'd3,  1'b1, 1'b1, 8'h1F, 24'hFFFFFF, 48'h000000_000000, 24'h000000, 1'b1, 56'h1F0000},
    '{8'd9, 5'd10, 1'b1, 1'b1, 8'h1F, 24'hFFFFFF, 48'h000000_000000, 24'h000000, 1'b1, 56'h00_1F0000_000000},
    '{8'd9, 5'd11, 1'b1, 1'b1, 8'h80, 24'h000000, 48'h000000_000000, 24'h000000, 1'b1, 56'hFF_800000_000000},
    // R10 unused code
    '{8'd10, 5'd25, 1'b0, 1'b0, 8'h00, 24'h000000, 48'hFFFFFF_FFFFFF, 24'h000000, 1'b0, 56'h0},
    // R11 immediate flag during a read has no effect
    '{8'd11, 5'd0, 1'b0, 1'b1, 8'h55, 24'h777777, 48'h000000_ABCDEF, 24'hABCDEF, 1'b0, 56'h0}
  };

  task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] s, input logic w, input logic im,
                       input logic [7:0] id, input logic [23:0] b, input logic [47:0] r);
    @(posedge clk);
    reg_sel = s; dir_wr = w; imm_sel = im; imm_data = id; bus_in = b; rd_raw = r;
    @(negedge clk);
  endtask

  initial begin
    // reset state: idle read of a zero register
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset bus_out", 56'(bus_out), 56'h0);
    check("R11 reset wr_en", 56'(wr_en), 56'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].sel, VEC[i].wr, VEC[i].imm, VEC[i].imm_d, VEC[i].bus, VEC[i].raw);
      check($sformatf("R%0d vec%0d bus_out", VEC[i].req, i), 56'(bus_out), 56'(VEC[i].exp_bus));
      check($sformatf("R%0d vec%0d wr_en", VEC[i].req, i), 56'(wr_en), 56'(VEC[i].exp_en));
      check($sformatf("R%0d vec%0d wr_val", VEC[i].req, i), wr_val, VEC[i].exp_val);
    end

    // R10: every unused code, both directions
    for (int c = 24; c < 32; c++) begin
      apply(5'(c), 1'b1, 1'b0, 8'hAA, 24'hFFFFFF, 48'hFFFFFF_FFFFFF);
      check($sformatf("R10 code%0d write en", c), 56'(wr_en), 56'h0);
      apply(5'(c), 1'b0, 1'b0, 8'hAA, 24'hFFFFFF, 48'hFFFFFF_FFFFFF);
      check($sformatf("R10 code%0d read bus", c), 56'(bus_out), 56'h0);
    end

    // R11: live register contents during a write must not reach the bus
    apply(5'd9, 1'b1, 1'b1, 8'h80, 24'h000000, 48'hFFFFFF_FFFFFF);
    check("R11 write quiet bus", 56'(bus_out), 56'h0);
    check("R8 ext imm with live raw", wr_val, 56'h80);

    // R2: all-ones extension
    apply(5'd8, 1'b0, 1'b0, 8'h00, 24'h0, 48'h0000FF);
    check("R2 ext FF read", 56'(bus_out), 56'hFFFFFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule